// File: doc/BRIEF.md
# MSI Snooping Cache-Line State Tracker

This block keeps the coherence state of a small, direct-mapped set of cache lines for one processor on a snooping bus. Each line holds a tag and one of three states: Modified, Shared or Invalid. The block stores no data. It only decides what each local access means for coherence and what each bus event means for the copies held here. The low address bits select a line. The upper address bits form the tag.

A local request port takes a read or a write and an address. One cycle later the block reports hit or miss and the state the access found. It also issues at most one bus event: a read, a read with intent to modify, or an upgrade. A snoop port takes the events that other agents broadcast. When a snooped event finds the dirty copy here, the block raises a flush request one cycle later. The requester rules and the snooper rules are two separate transition functions. If a snoop and a local request touch the same line in the same cycle, the snoop is applied first.

In a system, one copy of the block sits beside each processor. Each copy's broadcast is routed to the snoop ports of the other copies only. The bus has a single master, so at most one event is live per cycle.

Top module: `msi_line_tracker`

## Requirements
- R1: One cycle after a request is accepted, `rsp_valid` is 1. `rsp_state` gives the state the access found, after any snoop in the same cycle has been applied. The encoding is 0 Invalid, 1 Shared, 2 Modified. A line whose tag differs from the request counts as Invalid. `rsp_hit` is 1 exactly when that state is Shared or Modified.
- R2: A local read that finds Invalid moves the line to Shared. One cycle later it drives `bus_cmd` = 1 (read) and `bus_addr` = the request address.
- R3: A local write that finds Invalid moves the line to Modified and drives `bus_cmd` = 2 (read with intent to modify).
- R4: A local write that finds Shared moves the line to Modified and drives `bus_cmd` = 3 (upgrade).
- R5: A local read that finds Shared or Modified, and a local write that finds Modified, drive `bus_cmd` = 0 (no event) and leave the state unchanged.
- R6: A snooped read (1) that matches a Modified line raises `flush` one cycle later, with `flush_addr` = the snooped address, and moves the line to Shared. A snooped read that matches a Shared line leaves it Shared and raises no flush.
- R7: A snooped read with intent to modify (2) that matches a Modified line raises `flush` and moves the line to Invalid. A snooped 2 or 3 that matches a Shared line moves it to Invalid with no flush.
- R8: A snooped event aimed at an Invalid line, or at a line whose stored tag differs, has no effect and raises no flush.
- R9: Address bits [IDX_W-1:0] select the line and the rest form the tag. Suppose a request whose tag differs from the stored one finds the stored line Modified. Then one cycle later `evict` is 1 and `evict_addr` is the old tag joined with the index. The new tag then replaces the old one.
- R10: When a snoop and a local request hit the same line in one cycle, the snoop transition is applied first. The local transition then acts on its result.
- R11: With three copies on one event bus, at most one copy holds a given address Modified. After a read of a line that another copy holds Modified, both copies hold it Shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all lines Invalid |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Local request address |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Line was Shared or Modified with matching tag |
| rsp_state | output | 2 | State found by the request |
| bus_cmd | output | 2 | Event broadcast: 0 none, 1 read, 2 read-for-modify, 3 upgrade |
| bus_addr | output | ADDR_W | Address of the broadcast event |
| snp_valid | input | 1 | Snooped event present |
| snp_cmd | input | 2 | Snooped event code, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped event address |
| flush | output | 1 | Write-back of the dirty copy requested |
| flush_addr | output | ADDR_W | Address to write back |
| evict | output | 1 | Modified victim displaced by a local miss |
| evict_addr | output | ADDR_W | Address of the displaced victim |

## Verification
The assertions check several rules on every cycle. An Invalid line never leaves Invalid unless a local request targets it. A Modified line that sees a matching snooped read drops to Shared. Every flush follows a snoop. Every eviction and bus event follows a request, and the event kind agrees with the access type. Only the bench scenarios can show the rest. These are the exact state reported for each address across all three copies, the single-writer property across copies, the snoop-first ordering when both ports hit one line, and that mismatched tags are ignored. The bench uses an exhaustive sweep of every address, copy and access type, followed by random traffic, all compared against an arithmetic model.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPGR = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
(
    input  line_state_e cur_st,
    input  logic        is_write,
    output line_state_e nxt_st,
    output bus_cmd_e    cmd,
    output logic        hit
);
    always_comb begin
        nxt_st = cur_st;
        cmd    = CMD_NONE;
        hit    = (cur_st != ST_I);
        if (is_write) begin
            nxt_st = ST_M;
            unique case (cur_st)
                ST_I:    cmd = CMD_RDX;
                ST_S:    cmd = CMD_UPGR;
                default: cmd = CMD_NONE;
            endcase
        end else if (cur_st == ST_I) begin
            nxt_st = ST_S;
            cmd    = CMD_RD;
        end
    end
endmodule

// File: rtl/msi_snoop_fsm.sv
module msi_snoop_fsm
    import msi_pkg::*;
(
    input  line_state_e cur_st,
    input  bus_cmd_e    cmd,
    input  logic        match,
    output line_state_e nxt_st,
    output logic        flush
);
    always_comb begin
        nxt_st = cur_st;
        flush  = 1'b0;
        if (match) begin
            unique case (cur_st)
                ST_M: begin
                    if (cmd == CMD_RD) begin
                        nxt_st = ST_S;
                        flush  = 1'b1;
                    end else if (cmd != CMD_NONE) begin
                        nxt_st = ST_I;
                        flush  = (cmd == CMD_RDX);
                    end
                end
                ST_S: begin
                    if (cmd == CMD_RDX || cmd == CMD_UPGR) nxt_st = ST_I;
                end
                default: nxt_st = ST_I;
            endcase
        end
    end
endmodule

// File: rtl/msi_line_tracker.sv
module msi_line_tracker
    import msi_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_state,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_addr,
    output logic              evict,
    output logic [ADDR_W-1:0] evict_addr
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        line_state_e      st;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_LINES-1:0] ent;
        logic                   rsp_valid;
        logic                   rsp_hit;
        line_state_e            rsp_state;
        bus_cmd_e               bus_cmd;
        logic [ADDR_W-1:0]      bus_addr;
        logic                   flush;
        logic [ADDR_W-1:0]      flush_addr;
        logic                   evict;
        logic [ADDR_W-1:0]      evict_addr;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0] req_idx, snp_idx;
    logic [TAG_W-1:0] req_tag, snp_tag;
    assign req_idx = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    line_state_e            snp_nxt [NUM_LINES];
    logic [NUM_LINES-1:0]   snp_flush;
    logic [NUM_LINES-1:0]   snp_match;
    logic [NUM_LINES-1:0]   req_on_line;

    // Per-line snooper transition
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign snp_match[g]   = snp_valid && (snp_idx == IDX_W'(g))
                                && (q.ent[g].tag == snp_tag);
        assign req_on_line[g] = req_valid && (req_idx == IDX_W'(g));

        msi_snoop_fsm u_snoop (
            .cur_st (q.ent[g].st),
            .cmd    (bus_cmd_e'(snp_cmd)),
            .match  (snp_match[g]),
            .nxt_st (snp_nxt[g]),
            .flush  (snp_flush[g])
        );

        // R8: snooping never lifts a line out of Invalid
        assert_invalid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (q.ent[g].st == ST_I && !req_on_line[g]) |=> (q.ent[g].st == ST_I));

        // R6: snooped read on a Modified line leaves it Shared
        assert_m_to_s_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (q.ent[g].st == ST_M && snp_match[g] && snp_cmd == CMD_RD && !req_on_line[g])
            |=> (q.ent[g].st == ST_S));
    end

    // Local requester transition on the post-snoop state (R10)
    line_state_e loc_cur, loc_eff, loc_nxt;
    bus_cmd_e    loc_cmd;
    logic        loc_hit, tag_same, victim_dirty;

    assign loc_cur      = snp_nxt[req_idx];
    assign tag_same     = (q.ent[req_idx].tag == req_tag);
    assign loc_eff      = tag_same ? loc_cur : ST_I;
    assign victim_dirty = !tag_same && (loc_cur == ST_M);

    msi_req_fsm u_req (
        .cur_st   (loc_eff),
        .is_write (req_write),
        .nxt_st   (loc_nxt),
        .cmd      (loc_cmd),
        .hit      (loc_hit)
    );

    always_comb begin
        d = q;
        d.rsp_valid = req_valid;
        d.rsp_hit   = 1'b0;
        d.bus_cmd   = CMD_NONE;
        d.evict     = 1'b0;
        d.flush     = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            d.ent[i].st = snp_nxt[i];
            if (snp_flush[i]) begin
                d.flush      = 1'b1;
                d.flush_addr = snp_addr;
            end
        end
        if (req_valid) begin
            d.rsp_hit             = loc_hit;
            d.rsp_state           = loc_eff;
            d.bus_cmd             = loc_cmd;
            d.bus_addr            = req_addr;
            d.evict               = victim_dirty;
            d.evict_addr          = {q.ent[req_idx].tag, req_idx};
            d.ent[req_idx].tag    = req_tag;
            d.ent[req_idx].st     = loc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid  = q.rsp_valid;
    assign rsp_hit    = q.rsp_hit;
    assign rsp_state  = q.rsp_state;
    assign bus_cmd    = q.bus_cmd;
    assign bus_addr   = q.bus_addr;
    assign flush      = q.flush;
    assign flush_addr = q.flush_addr;
    assign evict      = q.evict;
    assign evict_addr = q.evict_addr;

    // R1: a response appears exactly one cycle after a request
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R2, R3, R4: events only follow requests; a read yields only the read event
    assert_cmd_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NONE) |-> ($past(req_valid) && ((bus_cmd == CMD_RD) == !$past(req_write))));

    // R6, R7: a flush is always the answer to a snooped event
    assert_flush_needs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ($past(snp_valid) && $past(snp_cmd) != CMD_NONE));

    // R9: an eviction is always caused by a local request
    assert_evict_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evict |-> $past(req_valid));

    // R1: hit agrees with the reported state
    assert_hit_matches_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit == (rsp_state != ST_I)));
endmodule

// File: tb/test_msi_line_tracker.sv
module test_msi_line_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int NL  = 4;
    localparam int IW  = 2;
    localparam int NC  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid [NC];
    logic          req_write [NC];
    logic [AW-1:0] req_addr  [NC];
    logic          rsp_valid [NC];
    logic          rsp_hit   [NC];
    logic [1:0]    rsp_state [NC];
    logic [1:0]    bus_cmd   [NC];
    logic [AW-1:0] bus_addr  [NC];
    logic          snp_valid [NC];
    logic [1:0]    snp_cmd   [NC];
    logic [AW-1:0] snp_addr  [NC];
    logic          flush     [NC];
    logic [AW-1:0] flush_addr[NC];
    logic          evict     [NC];
    logic [AW-1:0] evict_addr[NC];

    logic          ovr_en = 1'b0;
    logic [1:0]    ovr_cmd = 2'd0;
    logic [AW-1:0] ovr_addr = '0;

    // Event bus: each copy snoops every broadcast but its own
    always_comb begin
        for (int k = 0; k < NC; k++) begin
            snp_cmd[k]  = 2'd0;
            snp_addr[k] = '0;
            for (int j = 0; j < NC; j++) begin
                if (j != k && bus_cmd[j] != 2'd0) begin
                    snp_cmd[k]  = bus_cmd[j];
                    snp_addr[k] = bus_addr[j];
                end
            end
            if (k == 0 && ovr_en) begin
                snp_cmd[k]  = ovr_cmd;
                snp_addr[k] = ovr_addr;
            end
            snp_valid[k] = (snp_cmd[k] != 2'd0);
        end
    end

    for (genvar k = 0; k < NC; k++) begin : g_cpu
        msi_line_tracker #(.ADDR_W(AW), .NUM_LINES(NL)) i_msi_line_tracker (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[k]), .req_write(req_write[k]), .req_addr(req_addr[k]),
            .rsp_valid(rsp_valid[k]), .rsp_hit(rsp_hit[k]), .rsp_state(rsp_state[k]),
            .bus_cmd(bus_cmd[k]), .bus_addr(bus_addr[k]),
            .snp_valid(snp_valid[k]), .snp_cmd(snp_cmd[k]), .snp_addr(snp_addr[k]),
            .flush(flush[k]), .flush_addr(flush_addr[k]),
            .evict(evict[k]), .evict_addr(evict_addr[k])
        );
    end

    // Reference model: 0 I, 1 S, 2 M
    logic [1:0]    m_st  [NC][NL];
    logic [AW-IW-1:0] m_tag [NC][NL];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    task automatic chk(input string rq, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] eff_state(int c, logic [AW-1:0] a);
        int idx = int'(a[IW-1:0]);
        if (m_tag[c][idx] == a[AW-1:IW]) return m_st[c][idx];
        return 2'd0;
    endfunction

    // Snooper rules of the model, returns expected flush
    function automatic bit snoop_model(int c, logic [1:0] cmd, logic [AW-1:0] a);
        int idx = int'(a[IW-1:0]);
        logic [1:0] s = eff_state(c, a);
        if (cmd == 2'd0 || s == 2'd0) return 1'b0;
        if (s == 2'd2) begin
            if (cmd == 2'd1) begin m_st[c][idx] = 2'd1; return 1'b1; end
            m_st[c][idx] = 2'd0;
            return (cmd == 2'd2);
        end
        if (cmd != 2'd1) m_st[c][idx] = 2'd0;
        return 1'b0;
    endfunction

    task automatic do_req(int who, bit wr, logic [AW-1:0] a);
        int idx = int'(a[IW-1:0]);
        logic [1:0] cur = eff_state(who, a);
        logic [1:0] ecmd;
        logic [1:0] nxt;
        bit evx;
        bit efl [NC];
        int mcount;
        ecmd = 2'd0;
        nxt = cur;
        if (wr) begin
            nxt = 2'd2;
            ecmd = (cur == 2'd0) ? 2'd2 : (cur == 2'd1) ? 2'd3 : 2'd0;
        end else if (cur == 2'd0) begin
            nxt = 2'd1; ecmd = 2'd1;
        end
        evx = (m_tag[who][idx] != a[AW-1:IW]) && (m_st[who][idx] == 2'd2);

        req_valid[who] = 1'b1; req_write[who] = wr; req_addr[who] = a;
        @(negedge clk);
        req_valid[who] = 1'b0;
        chk("R1 rsp_valid", int'(rsp_valid[who]), 1);
        chk("R1 rsp_state", int'(rsp_state[who]), int'(cur));
        chk("R1 rsp_hit", int'(rsp_hit[who]), int'(cur != 2'd0));
        if (wr && cur == 2'd0)      chk("R3 bus_cmd rdx", int'(bus_cmd[who]), 2);
        else if (wr && cur == 2'd1) chk("R4 bus_cmd upgr", int'(bus_cmd[who]), 3);
        else if (!wr && cur == 2'd0) chk("R2 bus_cmd rd", int'(bus_cmd[who]), 1);
        else                        chk("R5 bus_cmd none", int'(bus_cmd[who]), 0);
        if (ecmd != 2'd0) chk("R2 bus_addr", int'(bus_addr[who]), int'(a));
        chk("R9 evict", int'(evict[who]), int'(evx));
        if (evx) chk("R9 evict_addr", int'(evict_addr[who]), int'({m_tag[who][idx], a[IW-1:0]}));

        m_tag[who][idx] = a[AW-1:IW];
        m_st[who][idx]  = nxt;
        for (int j = 0; j < NC; j++) efl[j] = (j == who) ? 1'b0 : snoop_model(j, ecmd, a);

        @(negedge clk);
        for (int j = 0; j < NC; j++) begin
            chk("R6 R7 R8 flush", int'(flush[j]), int'(efl[j]));
            if (efl[j]) chk("R6 flush_addr", int'(flush_addr[j]), int'(a));
        end
        mcount = 0;
        for (int j = 0; j < NC; j++) if (eff_state(j, a) == 2'd2) mcount++;
        chk("R11 single writer", int'(mcount <= 1), 1);
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin
            req_valid[k] = 1'b0; req_write[k] = 1'b0; req_addr[k] = '0;
            for (int i = 0; i < NL; i++) begin m_st[k][i] = 2'd0; m_tag[k][i] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            chk("R1 reset rsp_valid", int'(rsp_valid[k]), 0);
            chk("R1 reset flush", int'(flush[k]), 0);
            chk("R1 reset bus_cmd", int'(bus_cmd[k]), 0);
        end

        // R11: reader of a Modified line leaves both copies Shared
        do_req(0, 1'b1, 4'd6);
        do_req(1, 1'b0, 4'd6);
        do_req(0, 1'b0, 4'd6);
        chk("R11 writer now shared", int'(rsp_state[0]), 1);
        do_req(1, 1'b0, 4'd6);
        chk("R11 reader shared", int'(rsp_state[1]), 1);

        // R8: snoop with a different tag leaves a Modified line alone
        do_req(0, 1'b1, 4'd1);
        ovr_en = 1'b1; ovr_cmd = 2'd2; ovr_addr = 4'd5;
        @(negedge clk);
        ovr_en = 1'b0;
        @(negedge clk);
        chk("R8 tag mismatch no flush", int'(flush[0]), 0);
        do_req(0, 1'b0, 4'd1);
        chk("R8 tag mismatch keeps M", int'(rsp_state[0]), 2);

        // R10: snoop and request to the same line in one cycle
        do_req(0, 1'b1, 4'd9);
        ovr_en = 1'b1; ovr_cmd = 2'd1; ovr_addr = 4'd9;
        req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0] = 4'd9;
        @(negedge clk);
        ovr_en = 1'b0; req_valid[0] = 1'b0;
        chk("R10 state after snoop first", int'(rsp_state[0]), 1);
        chk("R10 no bus event", int'(bus_cmd[0]), 0);
        chk("R10 flush same cycle", int'(flush[0]), 1);
        m_st[0][1] = 2'd1;
        @(negedge clk);

        // Exhaustive sweep over address, copy and access type
        for (int a = 0; a < 16; a++)
            for (int who = 0; who < NC; who++)
                for (int wr = 0; wr < 2; wr++)
                    do_req(who, wr[0], a[AW-1:0]);

        // Random traffic
        for (int n = 0; n < 600; n++)
            do_req(int'($urandom_range(NC-1, 0)), 1'($urandom_range(1, 0)),
                   AW'($urandom_range(15, 0)));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule